// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block presents an 8-bit status word that a CPU reads to learn the state of four active-low modem handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input pin first passes through a multi-flop synchroniser. The upper nibble reports each line as "asserted" (1 when the pin is low). The lower nibble holds sticky change flags. A change flag is set when its line changes and is cleared when the CPU reads the word. An interrupt request stays high for as long as any flag is set.

In loopback mode the four asserted levels come from the block's own modem control outputs and not from the pins. Change detection then works on those looped values, so software can test the flag and interrupt path by toggling its own control bits. After reset a short settling window passes while the synchroniser fills. During this window no change is recorded, so the pin levels present at reset do not raise a false flag.

The read strobe is a single-cycle pulse. The word on `status_o` is valid in the same cycle as the strobe. The flags clear at the clock edge that ends that cycle. This block has no streaming data interface; all of its pins are plain control and status signals.

Top module: `mstat_reg`

## Requirements
- R1: In normal mode, `status_o[7]`, `[6]`, `[5]` and `[4]` equal the complements of `cd_n_i`, `ri_n_i`, `dsr_n_i` and `cts_n_i`. A pin change applied before clock edge 1 appears after edge 2, with SYNC_STAGES=2.
- R2: With `loop_en_i`=1, the upper nibble comes from `ctl_i`, and the pins have no effect on it. The control bits are: `ctl_i` bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2. The mapping is: bit 7 = `ctl_i[3]`, bit 6 = `ctl_i[2]`, bit 5 = `ctl_i[0]`, bit 4 = `ctl_i[1]`. It is combinational.
- R3: `status_o[3]` (CD), `[1]` (DSR) and `[0]` (CTS) set on any transition of their line. In normal mode a flag sets one edge after the level change shows in the upper nibble.
- R4: `status_o[2]` (RI) sets only when `ri_n_i` goes from 0 to 1, which is `status_o[6]` falling from 1 to 0. It never sets on the opposite transition.
- R5: A cycle with `rd_i`=1 clears all change flags at its closing edge. `status_o` in that cycle still shows the flags.
- R6: A change detected at the same edge as a read leaves that flag set. The other flags still clear.
- R7: Without a read, a set flag stays set. One transition sets a flag once, so after a read the flag stays 0 until a new transition occurs.
- R8: `irq_o` is 1 exactly when any of `status_o[3:0]` is 1.
- R9: In loopback mode, a change of a looped level sets the matching flag one edge later. RI follows R4: `ctl_i[2]` falling from 1 to 0 sets bit 2.
- R10: While reset is active, and for SYNC_STAGES+1 edges after it ends, the flags are 0 and `irq_o` is 0. This holds even when a pin is held low through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring indicator pin, active low |
| cd_n_i | input | 1 | Carrier detect pin, active low |
| loop_en_i | input | 1 | Loopback mode select |
| ctl_i | input | 4 | Modem control outputs: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2 |
| rd_i | input | 1 | Single-cycle read strobe for the status word |
| status_o | output | 8 | Asserted levels [7:4], change flags [3:0] |
| irq_o | output | 1 | Modem status interrupt request |

## Verification
The bench sweeps all sixteen pin patterns and all sixteen control patterns in an order that changes several lines at once. This catches a swapped loopback mapping, which would report DTR as clear-to-send, and an RI flag that fires on the wrong edge or on both edges. A read is timed to land on the same edge as a fresh clear-to-send change. A design that clears without regard to new events loses that change. Clear-to-send is held low through reset to expose a missing settling window, which would raise a false flag and interrupt just after reset. A long idle wait after a flag sets, followed by a read, catches a flag that fades without a read or that sets again without a new transition.

// File: rtl/mstat_pkg.sv
`timescale 1ns/1ps
package mstat_pkg;
  localparam int unsigned NLINES = 4;

  // line indices, shared by asserted levels and change flags
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_CD  = 3;

  // modem control output indices
  localparam int unsigned CTL_DTR  = 0;
  localparam int unsigned CTL_RTS  = 1;
  localparam int unsigned CTL_OUT1 = 2;
  localparam int unsigned CTL_OUT2 = 3;

  // lines whose flag counts only the asserted-to-deasserted edge
  localparam logic [NLINES-1:0] TRAIL_LINES = 4'b0100;

  typedef logic [NLINES-1:0] line_vec_t;
endpackage

// File: rtl/mstat_sync.sv
`timescale 1ns/1ps
module mstat_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RESET_VAL;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RESET_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mstat_settle.sv
`timescale 1ns/1ps
module mstat_settle #(
  parameter int unsigned SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic primed_o
);
  localparam int unsigned CW = $clog2(SETTLE + 1);
  logic [CW-1:0] cnt_q;

  assign primed_o = (cnt_q == CW'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!primed_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mstat_delta.sv
`timescale 1ns/1ps
module mstat_delta #(
  parameter int unsigned NLINES = 4,
  parameter logic [NLINES-1:0] TRAIL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              primed_i,
  input  logic [NLINES-1:0] lvl_i,
  input  logic              rd_i,
  output logic [NLINES-1:0] flag_o
);
  logic [NLINES-1:0] prev_q;
  logic [NLINES-1:0] flag_q;
  logic [NLINES-1:0] evt;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (TRAIL_MASK[i]) begin : g_trail
      assign evt[i] = primed_i & prev_q[i] & ~lvl_i[i];
    end else begin : g_any
      assign evt[i] = primed_i & (prev_q[i] ^ lvl_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= (flag_q & ~{NLINES{rd_i}}) | evt;
    end
  end

  assign flag_o = flag_q;

  // R7: without a read no flag ever drops
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/mstat_reg.sv
`timescale 1ns/1ps
module mstat_reg
  import mstat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       cd_n_i,
  input  logic       loop_en_i,
  input  logic [3:0] ctl_i,
  input  logic       rd_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  localparam int unsigned SETTLE = SYNC_STAGES + 1;

  line_vec_t pin_n;
  line_vec_t pin_sync_n;
  line_vec_t lvl_pin;
  line_vec_t lvl_loop;
  line_vec_t lvl;
  line_vec_t flag_w;
  logic      primed;

  always_comb begin
    pin_n          = '1;
    pin_n[IDX_CTS] = cts_n_i;
    pin_n[IDX_DSR] = dsr_n_i;
    pin_n[IDX_RI]  = ri_n_i;
    pin_n[IDX_CD]  = cd_n_i;
  end

  mstat_sync #(
    .WIDTH    (NLINES),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL('1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_n),
    .q_o  (pin_sync_n)
  );

  mstat_settle #(.SETTLE(SETTLE)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .primed_o(primed)
  );

  assign lvl_pin = ~pin_sync_n;

  always_comb begin
    lvl_loop          = '0;
    lvl_loop[IDX_CTS] = ctl_i[CTL_RTS];
    lvl_loop[IDX_DSR] = ctl_i[CTL_DTR];
    lvl_loop[IDX_RI]  = ctl_i[CTL_OUT1];
    lvl_loop[IDX_CD]  = ctl_i[CTL_OUT2];
  end

  assign lvl = loop_en_i ? lvl_loop : lvl_pin;

  mstat_delta #(
    .NLINES    (NLINES),
    .TRAIL_MASK(TRAIL_LINES)
  ) u_delta (
    .clk     (clk),
    .rst_n   (rst_n),
    .primed_i(primed),
    .lvl_i   (lvl),
    .rd_i    (rd_i),
    .flag_o  (flag_w)
  );

  assign status_o = {lvl, flag_w};
  assign irq_o    = |flag_w;

  // R4: RI flag rises only after the asserted level fell
  p_ri_trailing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_w[IDX_RI]) |-> ($past(lvl[IDX_RI], 2) && !$past(lvl[IDX_RI])));

  // R3: CD flag rises only after its level changed
  p_cd_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_w[IDX_CD]) |-> ($past(lvl[IDX_CD]) != $past(lvl[IDX_CD], 2)));

  // R5 and R6: after a read only fresh changes may leave a flag set
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> ((flag_w == '0) || ($past(lvl) != $past(lvl, 2))));

  // R10: nothing is recorded during the settling window
  p_settle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !irq_o);
endmodule

// File: tb/mstat_reg_bench.sv
`timescale 1ns/1ps
module mstat_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pins_n;
  logic       loop_en;
  logic [3:0] ctl;
  logic       rd;
  logic [7:0] status;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mstat_reg #(.SYNC_STAGES(2)) u_mstat_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cts_n_i  (pins_n[0]),
    .dsr_n_i  (pins_n[1]),
    .ri_n_i   (pins_n[2]),
    .cd_n_i   (pins_n[3]),
    .loop_en_i(loop_en),
    .ctl_i    (ctl),
    .rd_i     (rd),
    .status_o (status),
    .irq_o    (irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    step(1);
    rd = 1'b0;
  endtask

  // pin-side flags, index 0 CTS .. 3 CD; RI counts pin 0->1 only
  function automatic logic [3:0] pin_flags(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] f;
    f    = o ^ n;
    f[2] = ~o[2] & n[2];
    return f;
  endfunction

  // asserted-level flags; RI counts level 1->0 only
  function automatic logic [3:0] lvl_flags(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] f;
    f    = o ^ n;
    f[2] = o[2] & ~n[2];
    return f;
  endfunction

  function automatic logic [3:0] loop_lvl(input logic [3:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    logic [3:0] prevl;
    logic [3:0] saved;
    rst_n   = 1'b0;
    pins_n  = 4'b1110;
    loop_en = 1'b0;
    ctl     = 4'h0;
    rd      = 1'b0;
    step(4);
    chk("R10 flags in reset", {4'h0, status[3:0]}, 8'h00);
    chk("R10 irq in reset", {7'h0, irq}, 8'h00);
    rst_n = 1'b1;
    step(8);
    chk("R10 flags after reset", {4'h0, status[3:0]}, 8'h00);
    chk("R10 irq after reset", {7'h0, irq}, 8'h00);
    chk("R1 level after reset", {4'h0, status[7:4]}, {4'h0, ~pins_n});

    // R1 latency and R3 timing on CD
    pins_n = 4'b0110;
    step(1);
    chk("R1 not yet visible", {4'h0, status[7:4]}, 8'h01);
    step(1);
    chk("R1 visible after two edges", {4'h0, status[7:4]}, 8'h09);
    chk("R3 flag not yet set", {4'h0, status[3:0]}, 8'h00);
    step(1);
    chk("R3 CD flag set", {4'h0, status[3:0]}, 8'h08);
    do_read();
    chk("R5 cleared", {4'h0, status[3:0]}, 8'h00);

    // R4 explicit: ri_n 1->0 no flag, 0->1 flag
    pins_n[2] = 1'b0;
    step(4);
    chk("R4 no flag on ri_n fall", {4'h0, status[3:0]}, 8'h00);
    pins_n[2] = 1'b1;
    step(4);
    chk("R4 flag on ri_n rise", {4'h0, status[3:0]}, 8'h04);
    do_read();

    // sweep of all pin patterns: R1 R3 R4 R5 R8
    prev = pins_n;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] nv;
      logic [3:0] ef;
      nv     = 4'(k * 7 + 3);
      pins_n = nv;
      step(3);
      ef = pin_flags(prev, nv);
      chk("R1 sweep level", {4'h0, status[7:4]}, {4'h0, ~nv});
      chk("R3 R4 sweep flags", {4'h0, status[3:0]}, {4'h0, ef});
      chk("R8 sweep irq", {7'h0, irq}, {7'h0, |ef});
      do_read();
      chk("R5 sweep clear", {4'h0, status[3:0]}, 8'h00);
      chk("R8 sweep irq clear", {7'h0, irq}, 8'h00);
      prev = nv;
    end

    // R7 sticky, no re-set after read
    pins_n[1] = ~pins_n[1];
    step(3);
    step(20);
    chk("R7 flag held", {4'h0, status[3:0]}, 8'h02);
    chk("R8 irq held", {7'h0, irq}, 8'h01);
    do_read();
    step(10);
    chk("R7 no re-set", {4'h0, status[3:0]}, 8'h00);

    // R6 change on the read edge survives, older flag clears
    pins_n[3] = ~pins_n[3];
    step(3);
    chk("R6 setup CD flag", {4'h0, status[3:0]}, 8'h08);
    pins_n[0] = ~pins_n[0];
    step(2);
    do_read();
    chk("R6 CTS kept, CD cleared", {4'h0, status[3:0]}, 8'h01);
    do_read();

    // loopback: R2 and R9 sweep
    loop_en = 1'b1;
    ctl     = 4'h0;
    step(2);
    do_read();
    chk("R9 clear after mode switch", {4'h0, status[3:0]}, 8'h00);
    prevl = loop_lvl(4'h0);
    for (int k = 0; k < 16; k++) begin
      logic [3:0] c;
      c   = 4'(k * 5 + 1);
      ctl = c;
      #1;
      chk("R2 loop map", {4'h0, status[7:4]}, {4'h0, loop_lvl(c)});
      step(1);
      chk("R9 loop flags", {4'h0, status[3:0]}, {4'h0, lvl_flags(prevl, loop_lvl(c))});
      do_read();
      chk("R5 loop clear", {4'h0, status[3:0]}, 8'h00);
      prevl = loop_lvl(c);
    end

    // R2 pins ignored in loopback
    saved  = status[7:4];
    pins_n = ~pins_n;
    step(4);
    chk("R2 pins ignored level", {4'h0, status[7:4]}, {4'h0, saved});
    chk("R2 pins ignored flags", {4'h0, status[3:0]}, 8'h00);

    loop_en = 1'b0;
    step(4);
    do_read();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule